// File: doc/BRIEF.md
# Quadrature Multiply-Accumulate Response Analyzer

This block is the response-analysis end of a mixed-signal self-test path. It is a small-area substitute for a full FFT. Each digitized sample from the device under test is multiplied by two locally generated reference waves at a programmable test frequency. One reference is the sine and the other is the cosine. Each product is summed into its own accumulator over a programmed number of accepted samples. The two sums are the in-phase and quadrature content of the input at that one frequency, so magnitude and phase can both be derived from them downstream.

A measurement starts with a one-cycle start pulse. The pulse captures the frequency word, the phase word and the sample count, and clears both sums. A sweep is run by starting again with a new frequency word, which gives one spectral point per measurement. The phase word is loaded as the starting phase of the reference. This lets software cancel the phase error that register delay in the stimulus and return paths adds. The reference is a phase accumulator driving a quarter-wave table with symmetry folding.

Top module: `quad_mac_analyzer`

## Requirements
- R1: One clock edge after `start` is sampled high, both sums read zero and `done` is low, unless the count limit is zero.
- R2: The reference value for an 8-bit table phase P has four parts. The quadrant is P[7:6] and the index is k = P[5:0]. The folded index j is k in quadrants 0 and 2, and 63-k in quadrants 1 and 3. The magnitude is floor(2047*(2j+1)*(255-2j)/16384). The value is positive in quadrants 0 and 1 and negative in quadrants 2 and 3.
- R3: In clock cycle c after start (c = 0 is the first cycle after the start edge), the 16-bit in-phase phase is (phase word + c*frequency word) mod 65536. The table phase P is its top 8 bits. The quadrature table phase is that P plus 64, mod 256.
- R4: dc1 is the sum of sample times in-phase reference over the accepted samples. dc2 is the same sum using the quadrature reference. Samples are signed two's complement.
- R5: A sample is accepted only in a cycle with `sample_valid` high. The reference phase advances every clock cycle, whether or not a sample is valid.
- R6: After the programmed number of accepted samples, `done` goes high and both sums freeze. Further valid samples have no effect until the next start.
- R7: A count limit of zero gives `done` high and both sums zero one edge after start.
- R8: The frequency word, phase word and count limit are captured at start. Changing them during a run has no effect on that run.
- R9: A start during a run abandons that run and begins a fresh one.
- R10: The sums are 40 bits wide. A full run of 65535 full-scale products does not overflow.
- R11: While reset is held, both sums are zero and `done` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Capture settings, clear sums, begin a measurement |
| sample_valid | input | 1 | Sample strobe |
| sample_in | input | 12 | Signed sample from the converter path |
| freq_word | input | 16 | Phase increment per clock |
| phase_word | input | 16 | Starting reference phase (delay compensation) |
| sample_limit | input | 16 | Number of samples to accept |
| dc1_sum | output | 40 | In-phase accumulated sum |
| dc2_sum | output | 40 | Quadrature accumulated sum |
| done | output | 1 | Measurement complete |

## Verification
Some checks run on every cycle. These cover the sums holding whenever they are neither cleared nor enabled, and the sums clearing after start. They also cover the accepted-sample count staying within its limit, `done` rising only when the count equals the limit, a zero limit finishing at once, the captured frequency staying put during a run, and the reference never taking the most negative code. Other behaviour only the directed scenarios can show. This includes exact sum values for matched tones, offset phases and gapped pseudo-random input. The scenarios also show that mid-run changes to the inputs are ignored, that a restart discards earlier products, and that the accumulator width holds across a full-length full-scale run.

// File: rtl/qmac_pkg.sv
// Shared types for the quadrature analyzer.
// Assumes: nothing beyond standard SystemVerilog.
package qmac_pkg;
    // Quadrant of the reference phase; the name gives slope and sign.
    typedef enum logic [1:0] {
        QD_RISE  = 2'd0,
        QD_FALL  = 2'd1,
        QD_NRISE = 2'd2,
        QD_NFALL = 2'd3
    } quadrant_e;

    // Measurement state.
    typedef enum logic [1:0] {
        RUN_IDLE = 2'd0,
        RUN_BUSY = 2'd1,
        RUN_DONE = 2'd2
    } run_state_e;
endpackage

// File: rtl/qmac_sine_rom.sv
// Quarter-wave reference table with symmetry folding.
// The top two phase bits pick the quadrant and the rest index a
// QLEN-entry magnitude table. The table is sampled at bin midpoints, so
// no entry is zero and folding needs no end correction.
// Assumes: the phase input is already truncated to IDX_W+2 bits.
module qmac_sine_rom #(
    parameter int IDX_W = 6,
    parameter int REF_W = 12
) (
    input  logic [IDX_W+1:0]         phase_i,
    output logic signed [REF_W-1:0]  ref_o
);
    import qmac_pkg::*;

    localparam int     QLEN = 1 << IDX_W;
    localparam longint AMP  = (longint'(1) << (REF_W - 1)) - 1;
    localparam longint DEN  = 4 * longint'(QLEN) * longint'(QLEN);

    logic [REF_W-2:0] mag_tab [QLEN];

    // Parabolic sine approximation per quarter, computed at elaboration.
    for (genvar j = 0; j < QLEN; j++) begin : g_tab
        localparam longint MAGV =
            (AMP * longint'(2 * j + 1) * longint'(4 * QLEN - 2 * j - 1)) / DEN;
        assign mag_tab[j] = (REF_W - 1)'(MAGV);
    end

    quadrant_e               quad;
    logic [IDX_W-1:0]        idx;
    logic [REF_W-2:0]        mag;
    logic signed [REF_W-1:0] smag;

    // Fold the phase into the quarter table and apply the sign.
    always_comb begin
        quad = quadrant_e'(phase_i[IDX_W+1:IDX_W]);
        idx  = phase_i[IDX_W-1:0];
        if (quad == QD_FALL || quad == QD_NFALL) idx = ~idx;
        mag  = mag_tab[idx];
        smag = $signed({1'b0, mag});
        ref_o = (quad == QD_NRISE || quad == QD_NFALL) ? -smag : smag;
    end
endmodule

// File: rtl/qmac_nco.sv
// Phase accumulator for the reference pair.
// On load, the accumulator starts at the phase word (delay compensation)
// and the frequency word is captured. After that it advances by the
// captured word every clock. The quadrature phase is the in-phase phase
// plus a quarter turn.
// Assumes: OUT_W >= 3 and OUT_W <= PHASE_W.
module qmac_nco #(
    parameter int PHASE_W = 16,
    parameter int OUT_W   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PHASE_W-1:0] freq_in,
    input  logic [PHASE_W-1:0] phase_in,
    output logic [OUT_W-1:0]   phase_i,
    output logic [OUT_W-1:0]   phase_q
);
    localparam logic [OUT_W-1:0] QUARTER = OUT_W'(1) << (OUT_W - 2);

    logic [PHASE_W-1:0] acc_q;
    logic [PHASE_W-1:0] freq_q;

    // Capture settings on load, otherwise step the phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            freq_q <= '0;
        end else if (load) begin
            acc_q  <= phase_in;
            freq_q <= freq_in;
        end else begin
            acc_q  <= acc_q + freq_q;
        end
    end

    assign phase_i = acc_q[PHASE_W-1 -: OUT_W];
    assign phase_q = phase_i + QUARTER;

    // R8
    freq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(freq_q));
endmodule

// File: rtl/qmac_lane.sv
// One multiply-accumulate path: the signed sample times the signed
// reference, summed into an accumulator with guard bits.
// Assumes: ACC_W >= SAMPLE_W + REF_W; clear takes priority over enable.
module qmac_lane #(
    parameter int SAMPLE_W = 12,
    parameter int REF_W    = 12,
    parameter int ACC_W    = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clear,
    input  logic                      en,
    input  logic signed [SAMPLE_W-1:0] sample_i,
    input  logic signed [REF_W-1:0]    ref_i,
    output logic signed [ACC_W-1:0]    acc_o
);
    localparam int PROD_W = SAMPLE_W + REF_W;
    localparam logic [REF_W-1:0] REF_MIN = {1'b1, {(REF_W-1){1'b0}}};

    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  acc_q;

    assign prod = PROD_W'(sample_i) * PROD_W'(ref_i);

    // Clear on start, add the product on accepted samples, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     acc_q <= '0;
        else if (clear) acc_q <= '0;
        else if (en)    acc_q <= acc_q + ACC_W'(prod);
    end

    assign acc_o = acc_q;

    // R6
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && !en) |=> $stable(acc_q));
    // R1
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (acc_q == '0));
    // R2
    ref_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_i != REF_MIN);
endmodule

// File: rtl/qmac_seq.sv
// Measurement sequencer: counts accepted samples against the captured
// limit, drives clear and accumulate enables, and flags completion.
// Assumes: start is a single-cycle pulse; a zero limit completes at once.
module qmac_seq #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             valid,
    input  logic [CNT_W-1:0] limit_in,
    output logic             clear,
    output logic             acc_en,
    output logic             done
);
    import qmac_pkg::*;

    run_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] lim_q;
    logic [CNT_W-1:0] cnt_nxt;

    assign cnt_nxt = cnt_q + CNT_W'(1);

    // Start loads the run; accepted samples count toward the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= RUN_IDLE;
            cnt_q <= '0;
            lim_q <= '0;
        end else if (start) begin
            cnt_q <= '0;
            lim_q <= limit_in;
            st_q  <= (limit_in == '0) ? RUN_DONE : RUN_BUSY;
        end else if (st_q == RUN_BUSY && valid) begin
            cnt_q <= cnt_nxt;
            if (cnt_nxt == lim_q) st_q <= RUN_DONE;
        end
    end

    assign clear  = start;
    assign acc_en = (st_q == RUN_BUSY) && valid && !start;
    assign done   = (st_q == RUN_DONE);

    // R6
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q);
    // R6
    done_at_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> (cnt_q == lim_q));
    // R1
    start_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (cnt_q == '0));
    // R7
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && limit_in == '0) |=> done);
endmodule

// File: rtl/quad_mac_analyzer.sv
// Top of the quadrature multiply-accumulate analyzer. It holds the phase
// generator, the sequencer, and two lanes, each with its own table and
// accumulator. Lane 0 uses the in-phase reference and lane 1 the
// quadrature reference.
// Assumes: synchronous active-low reset; start is a one-cycle pulse.
module quad_mac_analyzer #(
    parameter int SAMPLE_W = 12,
    parameter int REF_W    = 12,
    parameter int PHASE_W  = 16,
    parameter int IDX_W    = 6,
    parameter int CNT_W    = 16
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   start,
    input  logic                                   sample_valid,
    input  logic [SAMPLE_W-1:0]                    sample_in,
    input  logic [PHASE_W-1:0]                     freq_word,
    input  logic [PHASE_W-1:0]                     phase_word,
    input  logic [CNT_W-1:0]                       sample_limit,
    output logic [SAMPLE_W+REF_W+CNT_W-1:0]        dc1_sum,
    output logic [SAMPLE_W+REF_W+CNT_W-1:0]        dc2_sum,
    output logic                                   done
);
    localparam int ACC_W = SAMPLE_W + REF_W + CNT_W;
    localparam int TAB_W = IDX_W + 2;
    localparam int LANES = 2;

    logic                     clear;
    logic                     acc_en;
    logic [TAB_W-1:0]         ph_i;
    logic [TAB_W-1:0]         ph_q;
    logic signed [ACC_W-1:0]  lane_acc [LANES];

    qmac_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .valid    (sample_valid),
        .limit_in (sample_limit),
        .clear    (clear),
        .acc_en   (acc_en),
        .done     (done)
    );

    qmac_nco #(.PHASE_W(PHASE_W), .OUT_W(TAB_W)) u_nco (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .freq_in  (freq_word),
        .phase_in (phase_word),
        .phase_i  (ph_i),
        .phase_q  (ph_q)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [TAB_W-1:0]        ph_sel;
        logic signed [REF_W-1:0] ref_w;

        assign ph_sel = (g == 0) ? ph_i : ph_q;

        qmac_sine_rom #(.IDX_W(IDX_W), .REF_W(REF_W)) u_rom (
            .phase_i (ph_sel),
            .ref_o   (ref_w)
        );

        qmac_lane #(.SAMPLE_W(SAMPLE_W), .REF_W(REF_W), .ACC_W(ACC_W)) u_mac (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear    (clear),
            .en       (acc_en),
            .sample_i ($signed(sample_in)),
            .ref_i    (ref_w),
            .acc_o    (lane_acc[g])
        );
    end

    assign dc1_sum = lane_acc[0];
    assign dc2_sum = lane_acc[1];
endmodule

// File: tb/quad_mac_analyzer_bench.sv
module quad_mac_analyzer_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        sample_valid = 1'b0;
    logic [11:0] sample_in = '0;
    logic [15:0] freq_word = '0;
    logic [15:0] phase_word = '0;
    logic [15:0] sample_limit = '0;
    logic signed [39:0] dc1_sum;
    logic signed [39:0] dc2_sum;
    logic        done;

    int total = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    quad_mac_analyzer u_quad_mac_analyzer (
        .clk(clk), .rst_n(rst_n), .start(start), .sample_valid(sample_valid),
        .sample_in(sample_in), .freq_word(freq_word), .phase_word(phase_word),
        .sample_limit(sample_limit), .dc1_sum(dc1_sum), .dc2_sum(dc2_sum),
        .done(done)
    );

    // Reference value from the 16-bit phase, as stated in R2 and R3.
    function automatic longint ref_of(input longint ph16);
        longint p, quad, k, j, m;
        p    = (ph16 & 16'hFFFF) >> 8;
        quad = (p >> 6) & 3;
        k    = p & 63;
        j    = (quad == 1 || quad == 3) ? 63 - k : k;
        m    = (2047 * (2*j + 1) * (255 - 2*j)) / 16384;
        return (quad >= 2) ? -m : m;
    endfunction

    task automatic check(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One measurement. smode: 0 constant, 1 pseudo-random, 2 tone at freq f.
    // vmode: 0 valid every cycle, 1 gaps (c%3==1 invalid).
    task automatic do_run(input string req, input longint f, input longint ph,
                          input longint lim, input int cycles, input int vmode,
                          input int smode, input longint sconst, input bit chk);
        longint e1 = 0, e2 = 0, acc = 0;
        @(negedge clk);
        start = 1'b1; freq_word = f[15:0]; phase_word = ph[15:0];
        sample_limit = lim[15:0]; sample_valid = 1'b0;
        @(negedge clk);
        start = 1'b0;
        // R8: scramble settings during the run
        freq_word = 16'h5A5A ^ f[15:0]; phase_word = 16'h3C3C ^ ph[15:0];
        sample_limit = 16'd3;
        if (chk) begin
            check({req, " R1 dc1 cleared"}, dc1_sum, 0);
            check({req, " R1 dc2 cleared"}, dc2_sum, 0);
            check({req, " R1 done after start"}, longint'(done), (lim == 0) ? 1 : 0);
        end
        for (int c = 0; c < cycles; c++) begin
            longint x, phc;
            bit v;
            v = (vmode == 0) ? 1'b1 : ((c % 3) != 1);
            if (smode == 0)      x = sconst;
            else if (smode == 1) x = ((longint'(c) * 733 + 91) % 4096) - 2048;
            else                 x = ref_of(longint'(c) * f);
            sample_valid = v;
            sample_in = x[11:0];
            if (v && acc < lim) begin
                phc = (ph + longint'(c) * f) & 16'hFFFF;
                e1 += x * ref_of(phc);
                e2 += x * ref_of(phc + 16'h4000);
                acc++;
            end
            @(negedge clk);
        end
        sample_valid = 1'b0;
        if (chk) begin
            check({req, " dc1"}, dc1_sum, e1);
            check({req, " dc2"}, dc2_sum, e2);
            check({req, " done"}, longint'(done), (acc >= lim) ? 1 : 0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R11 dc1 in reset", dc1_sum, 0);
        check("R11 dc2 in reset", dc2_sum, 0);
        check("R11 done in reset", longint'(done), 0);
        rst_n = 1'b1;
    endtask

    task automatic t_matched_tone();
        do_run("R2 R3 R4 matched tone", 16'h0400, 16'h0000, 64, 64, 0, 2, 0, 1'b1);
    endtask

    task automatic t_phase_offset();
        do_run("R3 R4 R8 phase offset", 16'h0400, 16'h2000, 64, 64, 0, 2, 0, 1'b1);
    endtask

    task automatic t_gaps();
        do_run("R5 R8 gapped pseudo", 16'h0A3D, 16'h1234, 40, 80, 1, 1, 0, 1'b1);
    endtask

    task automatic t_freeze();
        do_run("R6 freeze after limit", 16'h0777, 16'h0100, 10, 30, 0, 0, 1000, 1'b1);
    endtask

    task automatic t_zero_limit();
        do_run("R7 zero limit", 16'h0300, 16'h0000, 0, 10, 0, 0, -1500, 1'b1);
    endtask

    task automatic t_restart();
        do_run("R9 abandoned", 16'h1111, 16'h0800, 100, 7, 0, 0, 2000, 1'b0);
        do_run("R9 restart", 16'h0123, 16'h4567, 25, 30, 0, 1, 0, 1'b1);
    endtask

    task automatic t_full_scale();
        do_run("R10 full scale", 16'h0000, 16'h3F00, 65535, 65536, 0, 0, -2048, 1'b1);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        t_reset();
        t_matched_tone();
        t_phase_offset();
        t_gaps();
        t_freeze();
        t_zero_limit();
        t_restart();
        t_full_scale();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule